// File: doc/BRIEF.md
# Stack Pop Pointer Update Unit

This unit works out the address side of a single stack pop in a segmented processor. It takes the current stack pointer, the stack address-size attribute, the operand-size attribute and the kind of destination. From these it produces the address to read from, the number of bytes read, the updated stack pointer, and the base value that a stack-pointer-relative memory destination must use. Segment limit checks, paging and the memory access itself are handled elsewhere. The popped data arrives on an input so the unit can resolve the case where the destination is the stack pointer itself.

A request is presented with `pop_vld` and its result appears, registered, one clock later with `res_vld`. The result stays on the outputs until the next request. The stack size picks the pointer width that wraps: 16, 32 or 64 bits. The bits of the pointer above that width are kept unchanged. Size combinations that have no legal encoding raise `bad_op` and leave the pointer untouched.

Top module: `pop_sp_unit`

## Requirements
- R1: While `rst_n` is low and after its release until the first request, every output is zero.
- R2: `res_vld` is high in the cycle after a cycle with `pop_vld` high, and low otherwise. While `pop_vld` is low, the data outputs keep their previous values.
- R3: Size codes on `stk_sz` and `opd_sz` are 0 for 16 bits, 1 for 32 and 2 for 64, and 3 is reserved. The legal pairs (stack, operand) are (16,16), (16,32), (32,16), (32,32), (64,16) and (64,64). Any other pair gives `bad_op`=1, `sp_next` equal to the old pointer, and `rd_addr`, `rd_bytes` and `dst_base` equal to 0.
- R4: For a legal pair, `rd_bytes` is 2, 4 or 8 for operand size 16, 32 or 64.
- R5: For a legal pair, `rd_addr` is the old pointer's low stack-width bits, zero-extended.
- R6: For `dst_kind` 0 or 3 (plain destination) and `dst_kind` 2, `sp_next` equals the old pointer with its low stack-width bits increased by `rd_bytes` modulo 2 to the stack width. The bits above the stack width are unchanged.
- R7: For `dst_kind` 1 (the pointer is the destination), `sp_next` is the incremented pointer with its low operand-width bits replaced by the same bits of `pop_data`.
- R8: For `dst_kind` 2 (memory destination based on the pointer), `dst_base` is the incremented pointer's low stack-width bits, zero-extended. For every other kind, `dst_base` is 0.
- R9: `bad_op` is 0 for every legal pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pop_vld | input | 1 | Pop request this cycle |
| sp_cur | input | PTR_W | Current stack pointer |
| stk_sz | input | 2 | Stack address size code |
| opd_sz | input | 2 | Operand size code |
| dst_kind | input | 2 | Destination kind: 0 plain, 1 pointer, 2 pointer-based memory, 3 plain |
| pop_data | input | PTR_W | Data read from the old top of stack |
| res_vld | output | 1 | Result valid, one cycle after the request |
| rd_addr | output | PTR_W | Stack read address |
| rd_bytes | output | 4 | Width of the popped data in bytes |
| sp_next | output | PTR_W | Updated stack pointer |
| dst_base | output | PTR_W | Post-increment base for a pointer-based destination |
| bad_op | output | 1 | Illegal size combination |

## Verification
Directed pops place the pointer just below each wrap point: 0xFFFE for 16 bits, 0xFFFFFFFC for 32 bits and the top of the 64-bit range. This shows whether the carry stops at the stack width and whether the upper bits are kept. Each legal pair is repeated for every destination kind, which separates the pre-increment read address, the post-increment base and the overwrite by the popped value. Every reserved and forbidden pair is applied, as are idle cycles between requests. A run of random requests then covers mixed codes.

// File: rtl/pop_sp_pkg.sv
package pop_sp_pkg;
  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_RSV = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    DK_PLAIN = 2'd0,
    DK_SP    = 2'd1,
    DK_SPMEM = 2'd2,
    DK_ALT   = 2'd3
  } dst_e;

  localparam int STEP_W = 4;
  localparam int LANE_W = 16;
endpackage

// File: rtl/pop_sp_size_dec.sv
module pop_sp_size_dec
  import pop_sp_pkg::*;
(
  input  logic [1:0]        stk_sz,
  input  logic [1:0]        opd_sz,
  output logic              legal,
  output logic [STEP_W-1:0] step
);
  always_comb begin
    unique case (size_e'(stk_sz))
      SZ_16, SZ_32: legal = (opd_sz == SZ_16) || (opd_sz == SZ_32);
      SZ_64:        legal = (opd_sz == SZ_16) || (opd_sz == SZ_64);
      default:      legal = 1'b0;
    endcase
  end

  always_comb begin
    step = '0;
    if (legal) begin
      unique case (size_e'(opd_sz))
        SZ_16:   step = STEP_W'(2);
        SZ_32:   step = STEP_W'(4);
        SZ_64:   step = STEP_W'(8);
        default: step = '0;
      endcase
    end
  end
endmodule

// File: rtl/pop_sp_ptr_math.sv
module pop_sp_ptr_math
  import pop_sp_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic [PTR_W-1:0]  sp_cur,
  input  logic [1:0]        stk_sz,
  input  logic [1:0]        opd_sz,
  input  logic [STEP_W-1:0] step,
  input  logic [PTR_W-1:0]  pop_data,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [PTR_W-1:0]  sp_inc,
  output logic [PTR_W-1:0]  sp_wb,
  output logic [PTR_W-1:0]  base
);
  localparam int NLANE = PTR_W / LANE_W;

  logic [PTR_W-1:0] smask;
  logic [PTR_W-1:0] omask;
  logic [PTR_W-1:0] sum;

  function automatic int lanes_of(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign smask[g*LANE_W +: LANE_W] = {LANE_W{g < lanes_of(stk_sz)}};
    assign omask[g*LANE_W +: LANE_W] = {LANE_W{g < lanes_of(opd_sz)}};
  end

  assign sum     = sp_cur + PTR_W'(step);
  assign rd_addr = sp_cur & smask;
  assign sp_inc  = (sp_cur & ~smask) | (sum & smask);
  assign base    = sp_inc & smask;
  assign sp_wb   = (sp_inc & ~omask) | (pop_data & omask);
endmodule

// File: rtl/pop_sp_unit.sv
module pop_sp_unit
  import pop_sp_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_vld,
  input  logic [PTR_W-1:0]  sp_cur,
  input  logic [1:0]        stk_sz,
  input  logic [1:0]        opd_sz,
  input  logic [1:0]        dst_kind,
  input  logic [PTR_W-1:0]  pop_data,
  output logic              res_vld,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [3:0]        rd_bytes,
  output logic [PTR_W-1:0]  sp_next,
  output logic [PTR_W-1:0]  dst_base,
  output logic              bad_op
);
  logic              legal;
  logic [STEP_W-1:0] step;
  logic [PTR_W-1:0]  m_rd, m_inc, m_wb, m_base;

  logic [PTR_W-1:0]  rd_d, sp_d, base_d;
  logic [3:0]        bytes_d;
  logic              bad_d;

  pop_sp_size_dec u_dec (
    .stk_sz (stk_sz),
    .opd_sz (opd_sz),
    .legal  (legal),
    .step   (step)
  );

  pop_sp_ptr_math #(.PTR_W(PTR_W)) u_math (
    .sp_cur   (sp_cur),
    .stk_sz   (stk_sz),
    .opd_sz   (opd_sz),
    .step     (step),
    .pop_data (pop_data),
    .rd_addr  (m_rd),
    .sp_inc   (m_inc),
    .sp_wb    (m_wb),
    .base     (m_base)
  );

  always_comb begin
    rd_d    = '0;
    bytes_d = '0;
    sp_d    = sp_cur;
    base_d  = '0;
    bad_d   = 1'b1;
    if (legal) begin
      bad_d   = 1'b0;
      rd_d    = m_rd;
      bytes_d = 4'(step);
      sp_d    = (dst_e'(dst_kind) == DK_SP) ? m_wb : m_inc;
      base_d  = (dst_e'(dst_kind) == DK_SPMEM) ? m_base : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_vld <= 1'b0;
    else        res_vld <= pop_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr  <= '0;
      rd_bytes <= '0;
      sp_next  <= '0;
      dst_base <= '0;
      bad_op   <= 1'b0;
    end else if (pop_vld) begin
      rd_addr  <= rd_d;
      rd_bytes <= bytes_d;
      sp_next  <= sp_d;
      dst_base <= base_d;
      bad_op   <= bad_d;
    end
  end
endmodule

// File: rtl/pop_sp_unit_chk.sv
module pop_sp_unit_chk #(
  parameter int PTR_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pop_vld,
  input logic [PTR_W-1:0] sp_cur,
  input logic [1:0]       stk_sz,
  input logic [1:0]       opd_sz,
  input logic [1:0]       dst_kind,
  input logic             res_vld,
  input logic [PTR_W-1:0] rd_addr,
  input logic [3:0]       rd_bytes,
  input logic [PTR_W-1:0] sp_next,
  input logic [PTR_W-1:0] dst_base,
  input logic             bad_op
);
  logic illegal_in;
  assign illegal_in = (stk_sz == 2'd3) || (opd_sz == 2'd3) ||
                      (stk_sz == 2'd2 && opd_sz == 2'd1) ||
                      (stk_sz != 2'd2 && opd_sz == 2'd2);

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld |=> res_vld);
  p_vld_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_vld |=> !res_vld);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_vld |=> $stable(sp_next) && $stable(rd_addr) && $stable(dst_base));
  p_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld && illegal_in |=> bad_op && sp_next == $past(sp_cur) && rd_bytes == 4'd0);
  p_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld && !illegal_in |=> !bad_op);
  p_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_bytes) && !rd_bytes[0]);
  p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld && stk_sz == 2'd0 && !illegal_in && dst_kind != 2'd1
    |=> sp_next[PTR_W-1:16] == $past(sp_cur[PTR_W-1:16]));
  p_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld && stk_sz == 2'd2 && !illegal_in && dst_kind == 2'd2
    |=> dst_base == sp_next);
endmodule

bind pop_sp_unit pop_sp_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pop_vld  (pop_vld),
  .sp_cur   (sp_cur),
  .stk_sz   (stk_sz),
  .opd_sz   (opd_sz),
  .dst_kind (dst_kind),
  .res_vld  (res_vld),
  .rd_addr  (rd_addr),
  .rd_bytes (rd_bytes),
  .sp_next  (sp_next),
  .dst_base (dst_base),
  .bad_op   (bad_op)
);

// File: tb/test_pop_sp_unit.sv
module test_pop_sp_unit;
  localparam int PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pop_vld;
  logic [W-1:0] sp_cur;
  logic [1:0]   stk_sz, opd_sz, dst_kind;
  logic [W-1:0] pop_data;
  logic         res_vld;
  logic [W-1:0] rd_addr, sp_next, dst_base;
  logic [3:0]   rd_bytes;
  logic         bad_op;

  int checks = 0;
  int errors = 0;

  logic         e_vld;
  logic [W-1:0] e_rd, e_sp, e_base;
  logic [3:0]   e_bytes;
  logic         e_bad;

  always #(PERIOD/2) clk = ~clk;

  pop_sp_unit #(.PTR_W(W)) i_pop_sp_unit (
    .clk(clk), .rst_n(rst_n), .pop_vld(pop_vld), .sp_cur(sp_cur),
    .stk_sz(stk_sz), .opd_sz(opd_sz), .dst_kind(dst_kind), .pop_data(pop_data),
    .res_vld(res_vld), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
    .sp_next(sp_next), .dst_base(dst_base), .bad_op(bad_op)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int bits_of(logic [1:0] c);
    if (c == 2'd0) return 16;
    if (c == 2'd1) return 32;
    return 64;
  endfunction

  function automatic logic [W-1:0] low_mask(int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic model();
    bit ok;
    int sb, ob;
    logic [W-1:0] sm, om, inc;
    ok = (stk_sz == 0 && (opd_sz == 0 || opd_sz == 1)) ||
         (stk_sz == 1 && (opd_sz == 0 || opd_sz == 1)) ||
         (stk_sz == 2 && (opd_sz == 0 || opd_sz == 2));
    if (!ok) begin
      e_bad = 1; e_rd = 0; e_bytes = 0; e_sp = sp_cur; e_base = 0;
      return;
    end
    sb = bits_of(stk_sz);
    ob = bits_of(opd_sz);
    sm = low_mask(sb);
    om = low_mask(ob);
    e_bad   = 0;
    e_bytes = 4'(ob / 8);
    e_rd    = sp_cur & sm;
    inc     = (sp_cur & ~sm) | ((sp_cur + 64'(ob / 8)) & sm);
    e_sp    = (dst_kind == 2'd1) ? ((inc & ~om) | (pop_data & om)) : inc;
    e_base  = (dst_kind == 2'd2) ? (inc & sm) : '0;
  endtask

  task automatic compare(string tag);
    check("R2", {tag, " res_vld"}, W'(res_vld), W'(e_vld));
    check(e_bad ? "R3" : "R9", {tag, " bad_op"}, W'(bad_op), W'(e_bad));
    check(e_bad ? "R3" : "R4", {tag, " rd_bytes"}, W'(rd_bytes), W'(e_bytes));
    check(e_bad ? "R3" : "R5", {tag, " rd_addr"}, rd_addr, e_rd);
    check(e_bad ? "R3" : (dst_kind == 2'd1 ? "R7" : "R6"), {tag, " sp_next"}, sp_next, e_sp);
    check(e_bad ? "R3" : "R8", {tag, " dst_base"}, dst_base, e_base);
  endtask

  task automatic pop(string tag, logic v, logic [W-1:0] sp, logic [1:0] s,
                     logic [1:0] o, logic [1:0] d, logic [W-1:0] data);
    pop_vld = v; sp_cur = sp; stk_sz = s; opd_sz = o; dst_kind = d; pop_data = data;
    @(posedge clk);
    e_vld = v;
    if (v) model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; pop_vld = 0; sp_cur = '0; stk_sz = 0; opd_sz = 0; dst_kind = 0; pop_data = '0;
    e_vld = 0; e_rd = 0; e_sp = 0; e_base = 0; e_bytes = 0; e_bad = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    // R6 wrap points per stack width, upper bits kept
    pop("R6 s16o16 wrap", 1, 64'hA5A5_1234_5678_FFFE, 0, 0, 0, 64'h0);
    pop("R6 s16o32 wrap", 1, 64'hA5A5_1234_5678_FFFE, 0, 1, 0, 64'h0);
    pop("R6 s32o32 wrap", 1, 64'h1111_2222_FFFF_FFFC, 1, 1, 0, 64'h0);
    pop("R6 s32o16", 1, 64'h1111_2222_0000_1000, 1, 0, 0, 64'h0);
    pop("R6 s64o64 wrap", 1, 64'hFFFF_FFFF_FFFF_FFF8, 2, 2, 0, 64'h0);
    pop("R6 s64o16", 1, 64'h0000_7FFF_FFFF_FFFE, 2, 0, 3, 64'h0);
    // R7 pointer is destination
    pop("R7 s16o16", 1, 64'hDEAD_BEEF_0000_FFFE, 0, 0, 1, 64'h9999_8888_7777_4242);
    pop("R7 s32o32", 1, 64'hDEAD_BEEF_0000_0100, 1, 1, 1, 64'h9999_8888_7777_4242);
    pop("R7 s64o64", 1, 64'h0000_0000_0000_1000, 2, 2, 1, 64'h9999_8888_7777_4242);
    pop("R7 s16o32", 1, 64'hDEAD_BEEF_CAFE_0010, 0, 1, 1, 64'h9999_8888_7777_4242);
    // R8 pointer-based memory destination
    pop("R8 s16o16", 1, 64'hFFFF_0000_0000_FFFE, 0, 0, 2, 64'h0);
    pop("R8 s32o16", 1, 64'hFFFF_0000_FFFF_FFFE, 1, 0, 2, 64'h0);
    pop("R8 s64o64", 1, 64'h0123_4567_89AB_CDE0, 2, 2, 2, 64'h0);
    // R2 idle hold
    pop("R2 idle", 0, 64'h5555_5555_5555_5555, 1, 1, 2, 64'h0);
    pop("R2 idle2", 0, 64'h0, 3, 3, 1, 64'h0);
    // R3 illegal pairs
    pop("R3 s64o32", 1, 64'h0000_0000_0000_2000, 2, 1, 2, 64'h1);
    pop("R3 s16o64", 1, 64'h0000_0000_0000_2000, 0, 2, 1, 64'h1);
    pop("R3 s32o64", 1, 64'h0000_0000_0000_2000, 1, 2, 0, 64'h1);
    pop("R3 srsv", 1, 64'hABCD_0000_0000_2000, 3, 0, 0, 64'h1);
    pop("R3 orsv", 1, 64'hABCD_0000_0000_2000, 2, 3, 0, 64'h1);
    pop("R9 after bad", 1, 64'h0000_0000_0000_2000, 1, 1, 0, 64'h1);

    for (int i = 0; i < 60; i++) begin
      pop("random", 1'($urandom_range(0, 3) != 0),
          {$urandom, $urandom}, 2'($urandom), 2'($urandom), 2'($urandom),
          {$urandom, $urandom});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule